// File: doc/BRIEF.md
# Retirement Register Alias Table

This block keeps the committed mapping from each logical register to a physical register. Each retirement sends one commit request. The request names a destination logical register, the physical register that now holds its value, and a flag that says whether the commit installs that mapping. The block answers with the physical register that was mapped to the destination before this commit. The caller can then release that register for reuse.

The reply always carries the mapping as it stood before the commit. The table entry is rewritten only when the install flag is set. Logical register 0 is hardwired: it always maps to physical register 0, and no commit can change it. Reset maps every logical register to physical register 0. The logical register count and the physical index width are parameters, with defaults of 32 and 5 bits.

Top module: `commit_alias_table`

## Requirements
- R1: A request is accepted on a rising clock edge where `req_valid_i` and `req_ready_o` are both high. At most one request is accepted per cycle. `req_ready_o` is low during reset and stays high from the first clock edge after reset is released.
- R2: `rsp_valid_o` is high in the cycle after each accepted request and low in every other cycle.
- R3: `rsp_old_phys_o` gives the physical index that was mapped to `req_log_i` before the request was accepted. A mapping installed by the same request never appears in its own reply.
- R4: An accepted request with `req_install_i` = 1 and a nonzero `req_log_i` maps that logical register to `req_phys_i`.
- R5: An accepted request with `req_install_i` = 0 leaves the table unchanged. A later commit to the same register returns the same old index.
- R6: Reset, driven by `rst_ni` = 0 and asynchronous, maps every logical register to physical 0 and clears `rsp_valid_o` and `rsp_old_phys_o`.
- R7: Logical register 0 always replies with physical 0, and it is never rewritten, even when `req_install_i` = 1 and `req_phys_i` is nonzero.
- R8: Commits to the same register on consecutive cycles each return the index installed by the most recent earlier commit to that register with `req_install_i` = 1.
- R9: A request presented while `req_valid_i` = 0 has no effect on the table and produces no reply.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Commit request valid |
| req_ready_o | output | 1 | Commit request can be accepted |
| req_log_i | input | LOG_W | Destination logical register |
| req_phys_i | input | PHYS_W | New physical register for the destination |
| req_install_i | input | 1 | 1: install the new mapping; 0: lookup only |
| rsp_valid_o | output | 1 | Reply valid, one cycle after acceptance |
| rsp_old_phys_o | output | PHYS_W | Physical register mapped before this commit |

## Verification
The reply for a request accepted on edge k appears on edge k+1. The bench drives each request at a falling edge and checks the reply of that request at the next falling edge. In the vector loop, that same falling edge also drives the next request, so every back-to-back commit is checked without a gap. A table write made on edge k is seen only by a request accepted on edge k+1 or later. A repeat commit to the same register therefore tests both the read-before-write order and the forwarding of the value installed in the previous cycle. Ready and the reset state are checked at the falling edge next to the reset edges, where no register can still be settling.

// File: rtl/alias_tbl_pkg.sv
package alias_tbl_pkg;
  localparam int unsigned DEF_LOG_REGS = 32;
  localparam int unsigned DEF_PHYS_W   = 5;

  // Register 0 is architecturally pinned to physical 0.
  function automatic logic is_pinned(input int unsigned idx);
    return idx == 0;
  endfunction
endpackage

// File: rtl/alias_tbl_store.sv
module alias_tbl_store #(
  parameter int unsigned LOG_REGS = alias_tbl_pkg::DEF_LOG_REGS,
  parameter int unsigned PHYS_W   = alias_tbl_pkg::DEF_PHYS_W,
  parameter int unsigned LOG_W    = $clog2(LOG_REGS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [LOG_W-1:0]  wr_idx_i,
  input  logic [PHYS_W-1:0] wr_data_i,
  input  logic [LOG_W-1:0]  rd_idx_i,
  output logic [PHYS_W-1:0] rd_data_o
);
  logic [PHYS_W-1:0] ent [LOG_REGS];

  for (genvar g = 0; g < LOG_REGS; g++) begin : g_ent
    if (alias_tbl_pkg::is_pinned(g)) begin : g_pin
      assign ent[g] = '0;
    end else begin : g_reg
      logic [PHYS_W-1:0] q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= '0;
        else if (wr_en_i && (wr_idx_i == LOG_W'(g))) q <= wr_data_i;
      end
      assign ent[g] = q;
    end
  end

  assign rd_data_o = ent[rd_idx_i];
endmodule

// File: rtl/alias_tbl_rsp.sv
module alias_tbl_rsp #(
  parameter int unsigned PHYS_W = alias_tbl_pkg::DEF_PHYS_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fire_i,
  input  logic [PHYS_W-1:0] old_i,
  output logic              vld_o,
  output logic [PHYS_W-1:0] old_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_o <= 1'b0;
      old_o <= '0;
    end else begin
      vld_o <= fire_i;
      if (fire_i) old_o <= old_i;
    end
  end
endmodule

// File: rtl/commit_alias_table.sv
module commit_alias_table #(
  parameter int unsigned LOG_REGS = alias_tbl_pkg::DEF_LOG_REGS,
  parameter int unsigned PHYS_W   = alias_tbl_pkg::DEF_PHYS_W,
  parameter int unsigned LOG_W    = $clog2(LOG_REGS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [LOG_W-1:0]  req_log_i,
  input  logic [PHYS_W-1:0] req_phys_i,
  input  logic              req_install_i,
  output logic              rsp_valid_o,
  output logic [PHYS_W-1:0] rsp_old_phys_o
);
  logic              ready_q;
  logic              fire;
  logic              wr_en;
  logic [PHYS_W-1:0] rd_old;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ready_q <= 1'b0;
    else         ready_q <= 1'b1;
  end

  assign req_ready_o = ready_q;
  assign fire        = req_valid_i & ready_q;
  assign wr_en       = fire & req_install_i;

  // Read is combinational and the write lands at the edge, so the reply holds the pre-commit mapping.
  alias_tbl_store #(
    .LOG_REGS(LOG_REGS), .PHYS_W(PHYS_W), .LOG_W(LOG_W)
  ) u_store (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en),
    .wr_idx_i (req_log_i),
    .wr_data_i(req_phys_i),
    .rd_idx_i (req_log_i),
    .rd_data_o(rd_old)
  );

  alias_tbl_rsp #(.PHYS_W(PHYS_W)) u_rsp (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .fire_i(fire),
    .old_i (rd_old),
    .vld_o (rsp_valid_o),
    .old_o (rsp_old_phys_o)
  );
endmodule

// File: rtl/alias_tbl_chk.sv
module alias_tbl_chk #(
  parameter int unsigned LOG_W  = 5,
  parameter int unsigned PHYS_W = 5
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic              req_ready_o,
  input logic [LOG_W-1:0]  req_log_i,
  input logic [PHYS_W-1:0] req_phys_i,
  input logic              req_install_i,
  input logic              rsp_valid_o,
  input logic [PHYS_W-1:0] rsp_old_phys_o
);
  logic acc;
  assign acc = req_valid_i && req_ready_o;

  p_ready_up_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> req_ready_o);

  p_rsp_after_acc_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc |=> rsp_valid_o);

  p_no_rsp_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !acc |=> !rsp_valid_o);

  p_zero_reg_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && req_log_i == '0) |=> rsp_old_phys_o == '0);

  // R4 and R8: an install followed at once by a commit to the same register
  p_fwd_install_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && req_install_i && req_log_i != '0) ##1 (acc && req_log_i == $past(req_log_i))
      |=> rsp_old_phys_o == $past(req_phys_i, 2));

  p_keep_noinst_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && !req_install_i) ##1 (acc && req_log_i == $past(req_log_i))
      |=> rsp_old_phys_o == $past(rsp_old_phys_o));
endmodule

bind commit_alias_table alias_tbl_chk #(.LOG_W(LOG_W), .PHYS_W(PHYS_W)) u_chk (.*);

// File: tb/commit_alias_table_tb.sv
module commit_alias_table_tb;
  localparam int unsigned LOG_REGS = 32;
  localparam int unsigned PHYS_W   = 5;
  localparam int unsigned LOG_W    = $clog2(LOG_REGS);
  localparam int unsigned NVEC     = 12;

  typedef struct packed {
    logic [LOG_W-1:0]  lg;
    logic [PHYS_W-1:0] ph;
    logic              ins;
    logic [PHYS_W-1:0] exp_old;
  } vec_t;

  // Expected old index derived from the requirements, table starting all-zero.
  localparam vec_t VECS [NVEC] = '{
    '{5'd3,  5'd7,  1'b1, 5'd0},   // R3 R4
    '{5'd3,  5'd9,  1'b0, 5'd7},   // R8 R5
    '{5'd3,  5'd12, 1'b1, 5'd7},   // R5
    '{5'd5,  5'd31, 1'b1, 5'd0},
    '{5'd0,  5'd15, 1'b1, 5'd0},   // R7
    '{5'd0,  5'd4,  1'b0, 5'd0},   // R7
    '{5'd31, 5'd1,  1'b1, 5'd0},
    '{5'd31, 5'd2,  1'b1, 5'd1},   // R8
    '{5'd3,  5'd0,  1'b1, 5'd12},
    '{5'd5,  5'd6,  1'b0, 5'd31},
    '{5'd3,  5'd8,  1'b1, 5'd0},
    '{5'd31, 5'd0,  1'b0, 5'd2}
  };

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              req_valid_i = 1'b0;
  logic              req_ready_o;
  logic [LOG_W-1:0]  req_log_i = '0;
  logic [PHYS_W-1:0] req_phys_i = '0;
  logic              req_install_i = 1'b0;
  logic              rsp_valid_o;
  logic [PHYS_W-1:0] rsp_old_phys_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk_i = ~clk_i;

  commit_alias_table #(.LOG_REGS(LOG_REGS), .PHYS_W(PHYS_W)) u_dut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic drive(input logic v, input logic [LOG_W-1:0] lg,
                       input logic [PHYS_W-1:0] ph, input logic ins);
    req_valid_i = v; req_log_i = lg; req_phys_i = ph; req_install_i = ins;
  endtask

  task automatic commit_chk(input logic [LOG_W-1:0] lg, input logic [PHYS_W-1:0] ph,
                            input logic ins, input logic [PHYS_W-1:0] exp, input string req);
    @(negedge clk_i);
    drive(1'b1, lg, ph, ins);
    @(negedge clk_i);
    drive(1'b0, '0, '0, 1'b0);
    chk({req, " valid"}, 32'(rsp_valid_o), 32'd1);
    chk(req, 32'(rsp_old_phys_o), 32'(exp));
  endtask

  initial begin
    #100000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // R6 R1: reset state
    #12;
    chk("R1 ready in reset", 32'(req_ready_o), 32'd0);
    chk("R6 rsp_valid in reset", 32'(rsp_valid_o), 32'd0);
    chk("R6 rsp_old in reset", 32'(rsp_old_phys_o), 32'd0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1 ready after reset", 32'(req_ready_o), 32'd1);
    chk("R2 idle no rsp", 32'(rsp_valid_o), 32'd0);

    // Vector walk, back-to-back commits
    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk_i);
      if (i > 0) begin
        chk("R2 b2b valid", 32'(rsp_valid_o), 32'd1);
        chk($sformatf("R3 vec %0d", i - 1), 32'(rsp_old_phys_o), 32'(VECS[i-1].exp_old));
      end
      drive(1'b1, VECS[i].lg, VECS[i].ph, VECS[i].ins);
    end
    @(negedge clk_i);
    drive(1'b0, '0, '0, 1'b0);
    chk("R2 last valid", 32'(rsp_valid_o), 32'd1);
    chk("R3 last vec", 32'(rsp_old_phys_o), 32'(VECS[NVEC-1].exp_old));
    @(negedge clk_i);
    chk("R2 valid drops", 32'(rsp_valid_o), 32'd0);

    // R9: request fields with valid low
    drive(1'b0, 5'd3, 5'd20, 1'b1);
    @(negedge clk_i);
    chk("R9 no rsp", 32'(rsp_valid_o), 32'd0);
    drive(1'b0, '0, '0, 1'b0);
    commit_chk(5'd3, 5'd17, 1'b0, 5'd8, "R9 table untouched");

    // R4 R7: install to reg 0 is dropped, other reg installs
    commit_chk(5'd0, 5'd31, 1'b1, 5'd0, "R7 install reg0");
    commit_chk(5'd0, 5'd1, 1'b0, 5'd0, "R7 reg0 still 0");
    commit_chk(5'd17, 5'd25, 1'b1, 5'd0, "R4 install 17");
    commit_chk(5'd17, 5'd3, 1'b0, 5'd25, "R4 readback 17");

    // R6: reset mid-run clears the table
    @(negedge clk_i);
    rst_ni = 1'b0;
    #1;
    chk("R6 async rsp clear", 32'(rsp_old_phys_o), 32'd0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    commit_chk(5'd17, 5'd4, 1'b1, 5'd0, "R6 entry cleared");
    commit_chk(5'd31, 5'd4, 1'b1, 5'd0, "R6 entry 31 cleared");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule